// File: doc/BRIEF.md
# Exception Trap Prioritizer

This block watches three reset causes, three urgent hardware trap conditions and five error conditions, records each of them, and presents one exception at a time to the instruction sequencer. For the exception it presents, it gives the trap number, the vector address (the trap number times four), the priority class and a CPU priority level forced to 15. All three reset causes share one entry point, and so do all five error conditions. Each urgent trap has its own entry point. Inside a shared entry point, software tells the causes apart by reading the sticky trap flag register.

A condition is taken in on a clock edge. From then on it stays pending until the sequencer acknowledges the exception being presented. An acknowledge retires the presented cause, or its whole class when the class shares one vector. The next pending exception appears right after that edge. If a cause of a higher class arrives, it takes the place of a lower one being presented, and the lower one is held. Software clears flags by writing 0 to them. Acknowledges never change the flags.

Top module: `trap_prioritizer`

## Requirements
- R1: After a synchronous reset, exc_valid_o is 0, trap_class_o is 0, trap_num_o and vector_o are 0, cpu_level_o is 0 and trap_flags_o is all zeros.
- R2: The cause index is the same for the flags and the pending state: bit 0 is hardware reset, bit 1 is software reset, bit 2 is watchdog overflow, bit 3 is the non-maskable interrupt, bit 4 is stack overflow, bit 5 is stack underflow, and bits 6 to 10 are the five error conditions. A condition that is high at a clock edge sets its flag and its pending bit for the next cycle. Any number of causes may be set at the same edge.
- R3: Flags are sticky. A flag bit clears only at an edge where flag_wr_i is 1 and the matching bit of flag_wdata_i is 0. Writing 1 has no effect. If a bit is set and cleared at the same edge, the set wins.
- R4: If any reset cause is pending, the presented exception is the reset class: trap_class_o = 1, trap number 00h, vector 0.
- R5: If no reset cause is pending, pending urgent traps are presented with trap_class_o = 2. The order is: non-maskable interrupt first (trap 02h, vector 08h), then stack overflow (04h, 10h), then stack underflow (06h, 18h).
- R6: Error conditions are presented only when no reset and no urgent trap is pending. They all present trap_class_o = 3, trap number 0Ah and vector 28h.
- R7: cpu_level_o is 15 while an exception is presented and 0 otherwise.
- R8: An acknowledge while an exception is presented clears the pending state of that exception. For the reset class and the error class, this means every pending cause of the class. The next pending exception is presented after that same edge. Acknowledges leave the flags unchanged.
- R9: An acknowledge while nothing is presented has no effect. If a cause arrives at the same edge as the acknowledge of that same cause, the cause stays pending.
- R10: A higher-class cause that arrives while a lower one is presented is presented from the next cycle. The lower one stays pending and comes back after the higher one is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_cause_i | input | 3 | Reset causes: hardware, software, watchdog |
| trap_a_i | input | 3 | Urgent traps: NMI, stack overflow, stack underflow |
| err_b_i | input | 5 | Error conditions sharing one vector |
| ack_i | input | 1 | Sequencer has taken the presented exception |
| flag_wr_i | input | 1 | Flag register write strobe |
| flag_wdata_i | input | 11 | Write data; a 0 bit clears that flag |
| exc_valid_o | output | 1 | An exception is presented |
| vector_o | output | 24 | Vector address of the presented exception |
| trap_num_o | output | 8 | Trap number of the presented exception |
| trap_class_o | output | 2 | 0 none, 1 reset, 2 urgent trap, 3 error |
| cpu_level_o | output | 4 | Forced CPU priority level |
| trap_flags_o | output | 11 | Sticky trap flag register |

## Verification
The bench applies all 2048 combinations of the eleven causes as one simultaneous burst. It then acknowledges one exception at a time and checks the whole drain order. A selector that ranked an error above an urgent trap, or that retired only one error per acknowledge, would show a wrong class or an extra presentation. Flags are checked after the drain and again after a partial clear, which catches acknowledges that wrongly clear flags and writes of 1 that wrongly clear them. Directed sequences cover the remaining corners. A preempting higher-class trap must not lose the lower one it displaced. An acknowledge that lands with a new copy of the same cause must not drop that cause. An acknowledge while idle must change nothing.

// File: rtl/trap_pri_pkg.sv
package trap_pri_pkg;

    localparam int N_RST   = 3;
    localparam int N_A     = 3;
    localparam int N_B     = 5;
    localparam int N_CAUSE = N_RST + N_A + N_B;
    localparam int A_LO    = N_RST;
    localparam int B_LO    = N_RST + N_A;
    localparam int NUM_W   = 8;

    localparam logic [NUM_W-1:0] TN_RESET = 8'h00;
    localparam logic [NUM_W-1:0] TN_ERR   = 8'h0A;

    typedef enum logic [1:0] {
        TC_NONE  = 2'd0,
        TC_RESET = 2'd1,
        TC_URG   = 2'd2,
        TC_ERR   = 2'd3
    } trap_class_e;

    typedef struct packed {
        logic                valid;
        trap_class_e         cls;
        logic [NUM_W-1:0]    num;
        logic [N_CAUSE-1:0]  retire;
    } trap_sel_t;

    // Urgent traps take even trap numbers starting at 02h
    function automatic logic [NUM_W-1:0] urgent_num(input int idx);
        return NUM_W'(2 + 2 * idx);
    endfunction

    function automatic logic [N_CAUSE-1:0] span_mask(input int lo, input int n);
        logic [N_CAUSE-1:0] m;
        m = '0;
        for (int k = 0; k < N_CAUSE; k++) begin
            if (k >= lo && k < lo + n) m[k] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/trap_pending.sv
module trap_pending
    import trap_pri_pkg::*;
#(
    parameter int N = N_CAUSE
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic         ack_i,
    input  logic [N-1:0] retire_i,
    output logic [N-1:0] pend_o
);

    logic [N-1:0] drop;

    assign drop = ack_i ? retire_i : '0;

    always_ff @(posedge clk) begin
        if (rst) pend_o <= '0;
        else     pend_o <= (pend_o & ~drop) | set_i;
    end

    // R2
    pend_set_chk: assert property (@(posedge clk) disable iff (rst)
        (|set_i) |=> ((pend_o & $past(set_i)) == $past(set_i)));

    // R9
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ack_i |=> (($past(pend_o) & ~pend_o) == '0));

endmodule

// File: rtl/trap_select.sv
module trap_select
    import trap_pri_pkg::*;
(
    input  logic [N_CAUSE-1:0] pend_i,
    output trap_sel_t          sel_o
);

    always_comb begin
        sel_o        = '0;
        sel_o.cls    = TC_NONE;
        if (|pend_i[B_LO +: N_B]) begin
            sel_o.cls    = TC_ERR;
            sel_o.num    = TN_ERR;
            sel_o.retire = span_mask(B_LO, N_B);
        end
        // lowest index overwrites last, so it ranks highest
        for (int i = N_A - 1; i >= 0; i--) begin
            if (pend_i[A_LO + i]) begin
                sel_o.cls    = TC_URG;
                sel_o.num    = urgent_num(i);
                sel_o.retire = N_CAUSE'(1) << (A_LO + i);
            end
        end
        if (|pend_i[0 +: N_RST]) begin
            sel_o.cls    = TC_RESET;
            sel_o.num    = TN_RESET;
            sel_o.retire = span_mask(0, N_RST);
        end
        sel_o.valid = (sel_o.cls != TC_NONE);
    end

endmodule

// File: rtl/trap_flag_reg.sv
module trap_flag_reg
    import trap_pri_pkg::*;
#(
    parameter int N = N_CAUSE
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic         wr_i,
    input  logic [N-1:0] wdata_i,
    output logic [N-1:0] flags_o
);

    logic [N-1:0] clr;

    assign clr = wr_i ? ~wdata_i : '0;

    always_ff @(posedge clk) begin
        if (rst) flags_o <= '0;
        else     flags_o <= (flags_o & ~clr) | set_i;
    end

    // R2
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        (|set_i) |=> ((flags_o & $past(set_i)) == $past(set_i)));

    // R3
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> (($past(flags_o) & ~flags_o) == '0));

endmodule

// File: rtl/trap_prioritizer.sv
module trap_prioritizer
    import trap_pri_pkg::*;
#(
    parameter int VEC_W   = 24,
    parameter int LEVEL_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_RST-1:0]   rst_cause_i,
    input  logic [N_A-1:0]     trap_a_i,
    input  logic [N_B-1:0]     err_b_i,
    input  logic               ack_i,
    input  logic               flag_wr_i,
    input  logic [N_CAUSE-1:0] flag_wdata_i,
    output logic               exc_valid_o,
    output logic [VEC_W-1:0]   vector_o,
    output logic [NUM_W-1:0]   trap_num_o,
    output logic [1:0]         trap_class_o,
    output logic [LEVEL_W-1:0] cpu_level_o,
    output logic [N_CAUSE-1:0] trap_flags_o
);

    localparam int VEC_SHIFT = 2;

    logic [N_CAUSE-1:0] cause;
    logic [N_CAUSE-1:0] pend;
    trap_sel_t          sel;
    logic               take;

    assign cause = {err_b_i, trap_a_i, rst_cause_i};
    assign take  = ack_i & sel.valid;

    trap_pending #(.N(N_CAUSE)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .set_i    (cause),
        .ack_i    (take),
        .retire_i (sel.retire),
        .pend_o   (pend)
    );

    trap_select u_sel (
        .pend_i (pend),
        .sel_o  (sel)
    );

    trap_flag_reg #(.N(N_CAUSE)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_i   (cause),
        .wr_i    (flag_wr_i),
        .wdata_i (flag_wdata_i),
        .flags_o (trap_flags_o)
    );

    assign exc_valid_o  = sel.valid;
    assign trap_num_o   = sel.num;
    assign trap_class_o = sel.cls;
    assign vector_o     = VEC_W'(sel.num) << VEC_SHIFT;
    assign cpu_level_o  = sel.valid ? '1 : '0;

    // R4
    reset_first_chk: assert property (@(posedge clk) disable iff (rst)
        (|pend[0 +: N_RST]) |-> (trap_class_o == TC_RESET && vector_o == '0));

    // R6
    err_last_chk: assert property (@(posedge clk) disable iff (rst)
        (trap_class_o == TC_ERR) |-> (pend[B_LO-1:0] == '0));

    // R10
    preempt_chk: assert property (@(posedge clk) disable iff (rst)
        (trap_class_o == TC_ERR && !ack_i && (|trap_a_i)) |=> (trap_class_o == TC_URG));

endmodule

// File: tb/tb_trap_prioritizer.sv
module tb_trap_prioritizer;

    localparam int CLK_PERIOD = 10;
    localparam int NC = 11;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [2:0]      rst_cause = '0;
    logic [2:0]      trap_a = '0;
    logic [4:0]      err_b = '0;
    logic            ack = 1'b0;
    logic            fwr = 1'b0;
    logic [NC-1:0]   fwd = '0;
    logic            exc_valid;
    logic [23:0]     vector;
    logic [7:0]      trap_num;
    logic [1:0]      trap_class;
    logic [3:0]      cpu_level;
    logic [NC-1:0]   flags;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trap_prioritizer dut (
        .clk(clk), .rst(rst), .rst_cause_i(rst_cause), .trap_a_i(trap_a),
        .err_b_i(err_b), .ack_i(ack), .flag_wr_i(fwr), .flag_wdata_i(fwd),
        .exc_valid_o(exc_valid), .vector_o(vector), .trap_num_o(trap_num),
        .trap_class_o(trap_class), .cpu_level_o(cpu_level), .trap_flags_o(flags)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive for one edge from a negedge, return at the following negedge
    task automatic cyc(input logic [NC-1:0] c, input logic a, input logic w, input logic [NC-1:0] d);
        rst_cause = c[2:0]; trap_a = c[5:3]; err_b = c[10:6];
        ack = a; fwr = w; fwd = d;
        @(posedge clk);
        @(negedge clk);
        rst_cause = '0; trap_a = '0; err_b = '0; ack = 1'b0; fwr = 1'b0; fwd = '0;
    endtask

    function automatic int exp_cls(input logic [NC-1:0] pm);
        if (|pm[2:0]) return 1;
        if (|pm[5:3]) return 2;
        if (|pm[10:6]) return 3;
        return 0;
    endfunction

    function automatic int exp_num(input logic [NC-1:0] pm);
        if (|pm[2:0]) return 0;
        if (pm[3]) return 2;
        if (pm[4]) return 4;
        if (pm[5]) return 6;
        if (|pm[10:6]) return 10;
        return 0;
    endfunction

    function automatic logic [NC-1:0] retire(input logic [NC-1:0] pm);
        if (|pm[2:0]) return pm & ~11'h007;
        if (pm[3]) return pm & ~11'h008;
        if (pm[4]) return pm & ~11'h010;
        if (pm[5]) return pm & ~11'h020;
        return pm & ~11'h7C0;
    endfunction

    task automatic chk_out(input string req, input logic [NC-1:0] pm);
        int c;
        int n;
        c = exp_cls(pm);
        n = exp_num(pm);
        chk({req, " valid"}, 32'(exc_valid), (c != 0) ? 1 : 0);
        chk({req, " class"}, 32'(trap_class), 32'(c));
        chk({req, " num"}, 32'(trap_num), 32'(n));
        chk({req, " vector"}, 32'(vector), 32'(n * 4));
        chk("R7 level", 32'(cpu_level), (c != 0) ? 15 : 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [NC-1:0] pm;
        logic [NC-1:0] low;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk_out("R1", '0);
        chk("R1 flags", 32'(flags), 0);

        // R9 acknowledge while idle
        cyc('0, 1'b1, 1'b0, '0);
        chk_out("R9 idle ack", '0);
        chk("R9 idle ack flags", 32'(flags), 0);

        // sweep of every simultaneous cause combination
        for (int p = 0; p < (1 << NC); p++) begin
            cyc(NC'(p), 1'b0, 1'b0, '0);
            chk("R2 flags", 32'(flags), 32'(p));
            pm = NC'(p);
            chk_out("R4/R5/R6 present", pm);
            while (pm != '0) begin
                cyc('0, 1'b1, 1'b0, '0);
                pm = retire(pm);
                chk_out("R8 drain", pm);
            end
            chk("R8 flags kept", 32'(flags), 32'(p));
            low = NC'(p) & ~(NC'(p) - NC'(1));
            cyc('0, 1'b0, 1'b1, ~low);
            chk("R3 partial clear", 32'(flags), 32'(NC'(p) & ~low));
            cyc('0, 1'b0, 1'b1, '0);
            chk("R3 full clear", 32'(flags), 0);
        end

        // R3 writing ones changes nothing; set beats clear
        cyc(11'h080, 1'b0, 1'b1, '0);
        chk("R3 set wins", 32'(flags), 32'h080);
        cyc('0, 1'b0, 1'b1, '1);
        chk("R3 write ones", 32'(flags), 32'h080);
        cyc('0, 1'b1, 1'b1, '0);
        chk_out("R8 after err ack", '0);

        // R9 ack meets new copy of same cause
        cyc(11'h008, 1'b0, 1'b0, '0);
        chk_out("R9 nmi", 11'h008);
        cyc(11'h008, 1'b1, 1'b0, '0);
        chk_out("R9 re-arrival kept", 11'h008);
        cyc('0, 1'b1, 1'b0, '0);
        chk_out("R9 drained", '0);

        // R10 preemption with the lower cause held
        cyc(11'h040, 1'b0, 1'b0, '0);
        chk_out("R10 err shown", 11'h040);
        cyc(11'h010, 1'b0, 1'b0, '0);
        chk_out("R10 preempt", 11'h050);
        cyc(11'h004, 1'b0, 1'b0, '0);
        chk_out("R10 reset preempt", 11'h054);
        cyc('0, 1'b1, 1'b0, '0);
        chk_out("R10 back to urgent", 11'h050);
        cyc('0, 1'b1, 1'b0, '0);
        chk_out("R10 back to err", 11'h040);
        cyc('0, 1'b1, 1'b0, '0);
        chk_out("R10 idle", '0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule